// File: doc/BRIEF.md
# Disk block access sequencer

This block carries out one logical block access on a two-drive floppy slot. A request gives a block number, a two-bit command and a drive select. The block works out one track and two sectors from the block number and turns on the motor enable. It then drives a seek unit, an address-field reader and a sector data mover through request/done handshakes until both halves of the block have been handled, or until an error ends the access.

The seek unit is told where the head is believed to be and where it must go. The address reader reports the track and sector it found. The data mover is told the direction and which 256-byte half of the buffer to use. Failed address reads and wrong sectors use up a bounded retry budget. When that budget runs out the first time, the block recalibrates once by pretending the head is far out. When the drive select changes, the block waits a fixed time before stepping. When the disk was not already spinning, it waits for a motor-on time budget counted in `tick` pulses and then checks that the disk is turning.

Top module: `disk_block_seq`

## Requirements
- R1: A read or write command seeks to track `blk >> 3`. `seek_to` carries that track and `seek_from` carries the position last recorded for the selected drive. Each drive keeps its own recorded position.
- R2: The first sector is `{blk[1:0], 1'b0, blk[2]}` and the second sector is that value plus 2. A read or write moves the first sector with `xfer_half` = 0 and then the second sector with `xfer_half` = 1. `xfer_write` is 1 for a write.
- R3: Command 0 never raises `seek_req`, `adr_req` or `xfer_req`. It finishes with status 2'b10 when `wprot` is high and 2'b00 otherwise. Command bit 0 set means read and clear means write.
- R4: An address read with `adr_err`, or one on the right track with a sector other than the wanted one, counts as a failure. For each sector, 64 failures are tolerated and the 65th one exhausts the budget.
- R5: At the first exhaustion, the recorded position becomes twice itself plus 16, the drive seeks again, and the budget is refilled. A second exhaustion ends the access with I/O error status 2'b01. Each sector starts with the full budget and its own recalibration.
- R6: An address field that reports a track other than the target sets the recorded position to the reported track and causes a new seek. This uses neither the budget nor the recalibration.
- R7: A 16-bit motor counter is loaded with 0xE800 when a request is accepted. It counts up on every `tick` while the block is busy, including during waits and seeks. If `spinning` was low at acceptance, no address read starts until the counter has wrapped to zero. If `spinning` is still low at that point, the status is 2'b01.
- R8: When `unit` differs from the drive used by the previous request, the block waits 7 × 256 ticks before it issues its first seek or status sample. After reset, the previous drive is drive 0.
- R9: `xfer_err` on a write ends the access with status 2'b10. `xfer_err` on a read counts as a failure and the block retries.
- R10: `done` is high for exactly one cycle. At that point `status` is valid (00 ok, 01 I/O error, 10 write-protected) and `motor_en` has dropped. `motor_en` is high for the whole busy period.
- R11: A request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One pulse per 100 µs interval |
| req | input | 1 | Start an access (taken when idle) |
| cmd | input | 2 | 0 status, odd read, even non-zero write |
| blk | input | BLK_W | Logical block number |
| unit | input | 1 | Drive select within the slot |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code, valid with done |
| motor_en | output | 1 | Spindle motor enable |
| drive_sel | output | 1 | Selected drive |
| spinning | input | 1 | Disk rotation detected |
| wprot | input | 1 | Write-protect sense |
| seek_req | output | 1 | Seek request, held until seek_done |
| seek_from | output | BLK_W-1 | Believed head position |
| seek_to | output | BLK_W-1 | Target track |
| seek_done | input | 1 | Seek finished |
| adr_req | output | 1 | Read the next address field |
| adr_done | input | 1 | Address field result valid |
| adr_err | input | 1 | Address field unreadable |
| adr_trk | input | BLK_W-1 | Track found |
| adr_sec | input | 4 | Sector found |
| xfer_req | output | 1 | Move the current sector's data |
| xfer_write | output | 1 | 1 write, 0 read |
| xfer_half | output | 1 | Buffer half (second 256 bytes when 1) |
| xfer_done | input | 1 | Data move finished |
| xfer_err | input | 1 | Read checksum error or write refused |

## Verification
On every cycle, the assertions check the handshake discipline: at most one of the three requests is active, and a seek request is held until it is answered. They also check that a status command never moves the head or data, that the motor is enabled while the block is busy and off at completion, that done lasts one cycle with a legal code, and that a request during an access leaves the latched command untouched. Only the bench scenarios can show the outcomes that depend on the rest of the sequence. These are the sector order and halves, the retry and recalibration counts with the false position, the reseek after a wrong track, and the lengths of the drive-change and spin-up waits in ticks.

// File: rtl/disk_block_seq.sv
module disk_block_seq #(
  parameter int BLK_W = 9,
  parameter int RETRIES = 64,
  parameter int SWAP_WAITS = 7,
  parameter int SWAP_TICKS = 256,
  parameter logic [15:0] MOTOR_PRESET = 16'hE800,
  localparam int POS_W = BLK_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req,
  input  logic [1:0]       cmd,
  input  logic [BLK_W-1:0] blk,
  input  logic             unit,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic             motor_en,
  output logic             drive_sel,
  input  logic             spinning,
  input  logic             wprot,
  output logic             seek_req,
  output logic [POS_W-1:0] seek_from,
  output logic [POS_W-1:0] seek_to,
  input  logic             seek_done,
  output logic             adr_req,
  input  logic             adr_done,
  input  logic             adr_err,
  input  logic [POS_W-1:0] adr_trk,
  input  logic [3:0]       adr_sec,
  output logic             xfer_req,
  output logic             xfer_write,
  output logic             xfer_half,
  input  logic             xfer_done,
  input  logic             xfer_err
);
  localparam int RC_W = $clog2(RETRIES + 1);
  localparam int SW_N = SWAP_WAITS * SWAP_TICKS;
  localparam int SW_W = $clog2(SW_N + 1);
  localparam logic [1:0] ST_OK = 2'b00, ST_IO = 2'b01, ST_WP = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_SWAP, S_SEEK, S_SPIN, S_ADR, S_XFER, S_FIN} state_t;

  state_t           st;
  logic [1:0]       cmd_q, sts_q;
  logic [BLK_W-1:0] blk_q;
  logic             unit_q, last_unit, spin_q, half_q, recal_q;
  logic [RC_W-1:0]  rc;
  logic [SW_W-1:0]  sw_cnt;
  logic [15:0]      mon;
  logic [POS_W-1:0] pos [2];
  logic [3:0]       sec0, want;
  logic             fail;

  assign sec0       = {blk_q[1:0], 1'b0, blk_q[2]};
  assign want       = sec0 + {2'b00, half_q, 1'b0};
  assign seek_to    = POS_W'(blk_q[BLK_W-1:3]);
  assign seek_from  = pos[unit_q];
  assign busy       = (st != S_IDLE);
  assign seek_req   = (st == S_SEEK);
  assign adr_req    = (st == S_ADR);
  assign xfer_req   = (st == S_XFER);
  assign xfer_write = ~cmd_q[0];
  assign xfer_half  = half_q;
  assign drive_sel  = unit_q;

  assign fail = (st == S_ADR && adr_done &&
                 (adr_err || (adr_trk == seek_to && adr_sec != want))) ||
                (st == S_XFER && xfer_done && xfer_err && cmd_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_q     <= '0;
      sts_q     <= ST_OK;
      blk_q     <= '0;
      unit_q    <= 1'b0;
      last_unit <= 1'b0;
      spin_q    <= 1'b0;
      half_q    <= 1'b0;
      recal_q   <= 1'b0;
      rc        <= '0;
      sw_cnt    <= '0;
      mon       <= '0;
      done      <= 1'b0;
      status    <= ST_OK;
      motor_en  <= 1'b0;
      for (int i = 0; i < 2; i++) pos[i] <= '0;
    end else begin
      done <= 1'b0;
      if (busy && tick) mon <= mon + 16'd1;
      case (st)
        S_IDLE: if (req) begin
          cmd_q     <= cmd;
          blk_q     <= blk;
          unit_q    <= unit;
          last_unit <= unit;
          spin_q    <= spinning;
          half_q    <= 1'b0;
          recal_q   <= 1'b0;
          rc        <= RC_W'(RETRIES);
          sw_cnt    <= '0;
          mon       <= MOTOR_PRESET;
          motor_en  <= 1'b1;
          if (unit != last_unit) st <= S_SWAP;
          else if (cmd == 2'd0)  st <= S_SPIN;
          else                   st <= S_SEEK;
        end
        S_SWAP: if (tick) begin
          sw_cnt <= sw_cnt + 1'b1;
          if (sw_cnt == SW_W'(SW_N - 1)) st <= (cmd_q == 2'd0) ? S_SPIN : S_SEEK;
        end
        S_SEEK: if (seek_done) begin
          pos[unit_q] <= seek_to;
          st          <= S_SPIN;
        end
        S_SPIN: if (spin_q || !mon[15]) begin
          if (!spin_q && !spinning) begin
            sts_q <= ST_IO;
            st    <= S_FIN;
          end else begin
            spin_q <= 1'b1;
            if (cmd_q == 2'd0) begin
              sts_q <= wprot ? ST_WP : ST_OK;
              st    <= S_FIN;
            end else begin
              st <= S_ADR;
            end
          end
        end
        S_ADR: if (adr_done && !adr_err && adr_trk != seek_to) begin
          pos[unit_q] <= adr_trk;
          st          <= S_SEEK;
        end else if (adr_done && !fail) begin
          st <= S_XFER;
        end
        S_XFER: if (xfer_done && xfer_err && !cmd_q[0]) begin
          sts_q <= ST_WP;
          st    <= S_FIN;
        end else if (xfer_done && !xfer_err) begin
          if (!half_q) begin
            half_q  <= 1'b1;
            rc      <= RC_W'(RETRIES);
            recal_q <= 1'b0;
            st      <= S_ADR;
          end else begin
            sts_q <= ST_OK;
            st    <= S_FIN;
          end
        end
        S_FIN: begin
          done     <= 1'b1;
          status   <= sts_q;
          motor_en <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (fail) begin
        if (rc != '0) begin
          rc <= rc - 1'b1;
          st <= S_ADR;
        end else if (!recal_q) begin
          recal_q     <= 1'b1;
          rc          <= RC_W'(RETRIES);
          pos[unit_q] <= (pos[unit_q] << 1) + POS_W'(16);
          st          <= S_SEEK;
        end else begin
          sts_q <= ST_IO;
          st    <= S_FIN;
        end
      end
    end
  end
endmodule

// File: rtl/disk_block_seq_chk.sv
module disk_block_seq_chk #(
  parameter int BLK_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status,
  input logic             motor_en,
  input logic             seek_req,
  input logic             seek_done,
  input logic             adr_req,
  input logic             xfer_req,
  input logic [1:0]       cmd_q,
  input logic [BLK_W-1:0] blk_q
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n) done |-> !motor_en && !busy); // R10
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> status != 2'b11); // R10
  AST_MOTOR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> motor_en); // R10
  AST_SEEK_HELD: assert property (@(posedge clk) disable iff (!rst_n) seek_req && !seek_done |=> seek_req); // R1
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({seek_req, adr_req, xfer_req})); // R2
  AST_STATUS_NO_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_q == 2'd0 |-> !seek_req && !adr_req && !xfer_req); // R3
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && req |=> $stable(cmd_q) && $stable(blk_q)); // R11
endmodule

bind disk_block_seq disk_block_seq_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done), .status(status),
  .motor_en(motor_en), .seek_req(seek_req), .seek_done(seek_done), .adr_req(adr_req),
  .xfer_req(xfer_req), .cmd_q(cmd_q), .blk_q(blk_q)
);

// File: tb/test_disk_block_seq.sv
`timescale 1ns/1ps
module test_disk_block_seq;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic req = 1'b0, unit = 1'b0, spinning = 1'b1, wprot = 1'b0;
  logic [1:0] cmd = '0;
  logic [8:0] blk = '0;
  logic busy, done, motor_en, drive_sel, seek_req, adr_req, xfer_req, xfer_write, xfer_half;
  logic [1:0] status;
  logic [7:0] seek_from, seek_to;
  logic seek_done = 1'b0, adr_done = 1'b0, adr_err = 1'b0, xfer_done = 1'b0, xfer_err = 1'b0;
  logic [7:0] adr_trk = '0;
  logic [3:0] adr_sec = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_seek = 0, n_adr = 0, n_xfer = 0, n_done = 0;
  int sf_log[16], st_log[16], sk_cyc[16], ad_cyc[16], xs_log[16], xh_log[16], xw_log[16];
  int wrong_at = -1, xerr_at = -1;
  bit adr_err_mode = 0, sec_fix_mode = 0;
  logic [1:0] last_status = '0;
  logic [7:0] head = '0;
  logic [3:0] rot = '0;
  int acc_cyc;

  disk_block_seq i_disk_block_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .cmd(cmd), .blk(blk), .unit(unit),
    .busy(busy), .done(done), .status(status), .motor_en(motor_en), .drive_sel(drive_sel),
    .spinning(spinning), .wprot(wprot), .seek_req(seek_req), .seek_from(seek_from),
    .seek_to(seek_to), .seek_done(seek_done), .adr_req(adr_req), .adr_done(adr_done),
    .adr_err(adr_err), .adr_trk(adr_trk), .adr_sec(adr_sec), .xfer_req(xfer_req),
    .xfer_write(xfer_write), .xfer_half(xfer_half), .xfer_done(xfer_done), .xfer_err(xfer_err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Responder models for seek unit, address reader and data mover
  initial begin
    forever begin
      @(negedge clk);
      if (seek_done) seek_done = 1'b0;
      else if (seek_req) begin
        sf_log[n_seek % 16] = int'(seek_from);
        st_log[n_seek % 16] = int'(seek_to);
        sk_cyc[n_seek % 16] = cyc;
        head = seek_to;
        n_seek++;
        seek_done = 1'b1;
      end
      if (adr_done) begin adr_done = 1'b0; adr_err = 1'b0; end
      else if (adr_req) begin
        ad_cyc[n_adr % 16] = cyc;
        adr_trk = (n_adr == wrong_at) ? head + 8'd3 : head;
        adr_sec = sec_fix_mode ? 4'd15 : rot;
        rot = rot + 4'd1;
        adr_err = adr_err_mode;
        n_adr++;
        adr_done = 1'b1;
      end
      if (xfer_done) begin xfer_done = 1'b0; xfer_err = 1'b0; end
      else if (xfer_req) begin
        xs_log[n_xfer % 16] = int'(adr_sec);
        xh_log[n_xfer % 16] = int'(xfer_half);
        xw_log[n_xfer % 16] = int'(xfer_write);
        xfer_err = (n_xfer == xerr_at);
        n_xfer++;
        xfer_done = 1'b1;
      end
      if (done) begin n_done++; last_status = status; end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_rng(input string r, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", r, act, lo, hi);
    end
  endtask

  int s0, a0, x0, d0;

  task automatic run(input logic [1:0] c, input int b, input logic u);
    s0 = n_seek; a0 = n_adr; x0 = n_xfer; d0 = n_done;
    @(negedge clk);
    cmd = c; blk = 9'(b); unit = u; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    acc_cyc = cyc;
    do @(posedge clk); while (n_done == d0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset motor", int'(motor_en), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R2 reset handshakes", int'({seek_req, adr_req, xfer_req}), 0);
  endtask

  task automatic t_read_basic;
    int dd;
    s0 = n_seek; a0 = n_adr; x0 = n_xfer; d0 = n_done;
    @(negedge clk);
    cmd = 2'd1; blk = 9'd58; unit = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0; acc_cyc = cyc;
    chk("R10 busy and motor after accept", int'(busy && motor_en), 1);
    repeat (3) @(negedge clk);
    cmd = 2'd2; blk = 9'd5; req = 1'b1;   // R11: must be ignored
    @(negedge clk);
    req = 1'b0;
    do @(posedge clk); while (n_done == d0);
    repeat (4) @(negedge clk);
    dd = n_done - d0;
    chk("R11 single completion", dd, 1);
    chk("R1 seek count", n_seek - s0, 1);
    chk("R1 seek_to track 7", st_log[s0 % 16], 7);
    chk("R8 no swap wait", (sk_cyc[s0 % 16] - acc_cyc) < 10 ? 1 : 0, 1);
    chk("R2 two transfers", n_xfer - x0, 2);
    chk("R2 first sector 8", xs_log[x0 % 16], 8);
    chk("R2 second sector 10", xs_log[(x0 + 1) % 16], 10);
    chk("R2 halves", xh_log[x0 % 16] * 2 + xh_log[(x0 + 1) % 16], 1);
    chk("R2 read direction", xw_log[x0 % 16], 0);
    chk("R10 ok status", int'(last_status), 0);
    chk("R10 motor off", int'(motor_en), 0);
  endtask

  task automatic t_write_protect;
    xerr_at = n_xfer;
    run(2'd2, 5, 1'b0);
    xerr_at = -1;
    chk("R1 seek_from tracks position", sf_log[s0 % 16], 7);
    chk("R1 seek_to track 0", st_log[s0 % 16], 0);
    chk("R2 sector 5", xs_log[x0 % 16], 5);
    chk("R2 write direction", xw_log[x0 % 16], 1);
    chk("R9 one transfer only", n_xfer - x0, 1);
    chk("R9 write-protect status", int'(last_status), 2);
  endtask

  task automatic t_status_cmd;
    wprot = 1'b1;
    run(2'd0, 58, 1'b0);
    chk("R3 no motion", (n_seek - s0) + (n_adr - a0) + (n_xfer - x0), 0);
    chk("R3 protected", int'(last_status), 2);
    wprot = 1'b0;
    run(2'd0, 58, 1'b0);
    chk("R3 not protected", int'(last_status), 0);
    chk("R3 no motion again", (n_seek - s0) + (n_adr - a0) + (n_xfer - x0), 0);
  endtask

  task automatic t_read_retry;
    xerr_at = n_xfer;
    run(2'd1, 58, 1'b0);
    xerr_at = -1;
    chk("R9 read error retried", n_xfer - x0, 3);
    chk("R9 retried same sector", xs_log[(x0 + 1) % 16], 8);
    chk("R9 read retry ok", int'(last_status), 0);
  endtask

  task automatic t_wrong_track;
    wrong_at = n_adr;
    run(2'd1, 58, 1'b0);
    wrong_at = -1;
    chk("R6 reseek count", n_seek - s0, 2);
    chk("R6 position from found track", sf_log[(s0 + 1) % 16], 10);
    chk("R6 status ok", int'(last_status), 0);
  endtask

  task automatic t_exhaust_err;
    adr_err_mode = 1;
    run(2'd1, 58, 1'b0);
    adr_err_mode = 0;
    chk("R4 attempts with one recal", n_adr - a0, 130);
    chk("R5 seeks incl recal", n_seek - s0, 2);
    chk("R5 false position", sf_log[(s0 + 1) % 16], 30);
    chk("R5 io error", int'(last_status), 1);
  endtask

  task automatic t_exhaust_sector;
    sec_fix_mode = 1;
    run(2'd1, 58, 1'b0);
    sec_fix_mode = 0;
    chk("R4 wrong sector counts", n_adr - a0, 130);
    chk("R4 no transfer", n_xfer - x0, 0);
    chk("R4 io error", int'(last_status), 1);
  endtask

  task automatic t_drive_swap;
    run(2'd1, 8, 1'b1);
    chk_rng("R8 swap wait", sk_cyc[s0 % 16] - acc_cyc, 1792, 1800);
    chk("R1 per-drive position", sf_log[s0 % 16], 0);
    chk("R2 sectors 0 then 2", xs_log[x0 % 16] * 16 + xs_log[(x0 + 1) % 16], 2);
    chk("R8 status ok", int'(last_status), 0);
  endtask

  task automatic t_spin_up;
    spinning = 1'b0;
    fork
      run(2'd1, 8, 1'b1);
      begin repeat (200) @(negedge clk); spinning = 1'b1; end
    join
    chk_rng("R7 spin-up wait", ad_cyc[a0 % 16] - acc_cyc, 6144, 6160);
    chk("R7 spun up ok", int'(last_status), 0);
  endtask

  task automatic t_no_spin;
    spinning = 1'b0;
    run(2'd1, 8, 1'b1);
    chk("R7 no address read", n_adr - a0, 0);
    chk("R7 io error", int'(last_status), 1);
    spinning = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write_protect();
    t_status_cmd();
    t_read_retry();
    t_wrong_track();
    t_exhaust_err();
    t_exhaust_sector();
    t_drive_swap();
    t_spin_up();
    t_no_spin();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (R10 done never seen) actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule